// File: doc/BRIEF.md
# Receive Loss-of-Signal and All-Ones Alarm Monitor

This block watches a recovered E1 receive bit stream, one bit per `bitEn` pulse, and keeps two level alarms. The loss-of-signal alarm (`rlos`) is raised when the line has carried too many zeros in a row. How many zeros that takes depends on the mode: a short limit by default, a much longer limit in the alternative mode, and a longer one still when the extended option is on. The alarm drops only after the recent traffic passes a density test. That test runs over a 32-bit sliding window. In the alternative mode the test must also keep passing for a sustained stretch before the alarm drops.

The all-ones alarm (`ais`) counts zeros in consecutive, non-overlapping 512-bit blocks. At the end of each block it sets if the block held two zeros or fewer, and clears if the block held three or more. Only the digital zero/one pattern is examined. An optional `levelOk` input stands in for an analog "level above threshold" indication. A bit received while `levelOk` is low is treated as a zero. Tie `levelOk` high when no such indication exists.

Top module: `rx_alarm_monitor`

## Requirements
- R1: While and after reset, before any bit is accepted, `rlos` and `ais` are 0.
- R2: With `modeAlt`=0 and `extLos`=0, `rlos` becomes 1 on the clock edge that accepts the 32nd consecutive zero, and not before it.
- R3: With `modeAlt`=1 and `extLos`=0, `rlos` becomes 1 on the edge that accepts the 2049th consecutive zero. After 2048 zeros it is still 0.
- R4: With `extLos`=1 (either `modeAlt`), `rlos` becomes 1 on the edge that accepts the 4096th consecutive zero, and not before it.
- R5: An accepted one restarts the consecutive-zero count from zero, so that two runs of 31 zeros separated by a one do not raise `rlos`.
- R6: With `modeAlt`=0, a raised `rlos` clears on the edge that accepts a bit for which all of the following hold: at least 32 bits have been accepted since reset; the last 32 accepted bits hold at least 4 ones; and those 32 bits contain no run of 16 or more zeros. If a declare and a clear fall on the same edge, the declare wins.
- R7: With `modeAlt`=1, `rlos` clears only on the edge that accepts the 33rd consecutive bit for which the R6 window test passes.
- R8: Accepted bits are grouped into consecutive 512-bit blocks counted from reset. On the edge that accepts the last bit of a block, `ais` becomes 1 if that block held 2 zeros or fewer. `ais` changes on no other edge.
- R9: On the edge that accepts the last bit of a block holding 3 or more zeros, `ais` becomes 0.
- R10: Cycles with `bitEn`=0 change neither alarm, the zero count, the window nor the block position.
- R11: A bit accepted while `levelOk`=0 counts as a zero for every rule above, whatever `rxBit` is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitEn | input | 1 | Accept `rxBit` on this edge |
| rxBit | input | 1 | Recovered receive bit |
| levelOk | input | 1 | Line level above threshold; tie high if unused |
| modeAlt | input | 1 | 0: short declare limit; 1: long limit and sustained clear |
| extLos | input | 1 | 1: extended declare limit, overrides `modeAlt` for declaring |
| rlos | output | 1 | Loss-of-signal alarm |
| ais | output | 1 | All-ones alarm |

## Verification
Both alarms are registered. Each one reflects the bit accepted on an edge right after that same edge, with no extra pipeline stage. An idle cycle leaves them as they were. For each accepted bit or idle cycle, the driver advances a bit-level reference model just after the rising edge and queues the expected alarm pair. The monitor pops and compares that pair at the next falling edge, which is the first stable point after the edge that produced it. Block-boundary checks for the all-ones alarm use the model's own block position to align the stimulus. They do not use the design's position.

// File: rtl/rx_alarm_pkg.sv
package rx_alarm_pkg;

  // strobes issued by the control to the datapath
  typedef struct packed {
    logic take;      // a bit is accepted this edge
    logic blockEnd;  // the accepted bit closes a 512-bit block
  } ctlStrobe_t;

  // status returned by the datapath, all describing the state after this bit
  typedef struct packed {
    logic runHit;      // consecutive-zero count has reached the active limit
    logic windowGood;  // sliding-window density test passes
    logic altGoodMet;  // window test has passed long enough for the alternative mode
    logic aisQuiet;    // current block holds few enough zeros for the all-ones alarm
  } dpStatus_t;

endpackage

// File: rtl/rx_alarm_datapath.sv
module rx_alarm_datapath
  import rx_alarm_pkg::*;
#(
  parameter int WIN         = 32,
  parameter int MIN_ONES    = 4,
  parameter int MAX_ZRUN    = 15,
  parameter int SHORT_LIMIT = 32,
  parameter int LONG_LIMIT  = 2049,
  parameter int EXT_LIMIT   = 4096,
  parameter int ALT_GOOD    = 33,
  parameter int AIS_SET_MAX = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t strobe,
  input  logic       rxBit,
  input  logic       levelOk,
  input  logic       modeAlt,
  input  logic       extLos,
  output dpStatus_t  status
);

  localparam int RUN_W  = $clog2(EXT_LIMIT + 1);
  localparam int GOOD_W = $clog2(ALT_GOOD + 1);
  localparam int CNT_W  = $clog2(WIN + 1);
  localparam int ZER_W  = $clog2(AIS_SET_MAX + 2);
  localparam int SLICES = WIN - MAX_ZRUN;
  localparam int SPAN   = MAX_ZRUN + 1;

  logic               effBit;
  logic [RUN_W-1:0]   zeroRun, runNext, runLimit;
  logic [WIN-1:0]     window, winNext;
  logic [CNT_W-1:0]   fill, fillNext, onesNext;
  logic [GOOD_W-1:0]  goodRun, goodRunNext;
  logic [ZER_W-1:0]   blkZeros, zerosNext;
  logic [SLICES-1:0]  longRun;
  logic               goodNext;

  assign effBit = rxBit & levelOk;

  always_comb begin
    if (extLos)       runLimit = RUN_W'(EXT_LIMIT);
    else if (modeAlt) runLimit = RUN_W'(LONG_LIMIT);
    else              runLimit = RUN_W'(SHORT_LIMIT);
  end

  always_comb begin
    if (effBit)                 runNext = '0;
    else if (zeroRun < runLimit) runNext = zeroRun + 1'b1;
    else                        runNext = zeroRun;
  end

  assign winNext  = {window[WIN-2:0], effBit};
  assign fillNext = (fill < CNT_W'(WIN)) ? fill + 1'b1 : fill;
  assign onesNext = CNT_W'($countones(winNext));

  // every span of MAX_ZRUN+1 bits that is all zeros marks a run that is too long
  for (genvar i = 0; i < SLICES; i++) begin : gSlice
    assign longRun[i] = ~|winNext[i +: SPAN];
  end

  assign goodNext = (fillNext == CNT_W'(WIN)) &&
                    (onesNext >= CNT_W'(MIN_ONES)) && !(|longRun);

  always_comb begin
    if (!goodNext)                      goodRunNext = '0;
    else if (goodRun < GOOD_W'(ALT_GOOD)) goodRunNext = goodRun + 1'b1;
    else                                goodRunNext = goodRun;
  end

  always_comb begin
    if (!effBit && blkZeros < ZER_W'(AIS_SET_MAX + 1)) zerosNext = blkZeros + 1'b1;
    else                                              zerosNext = blkZeros;
  end

  assign status.runHit     = runNext >= runLimit;
  assign status.windowGood = goodNext;
  assign status.altGoodMet = goodRunNext >= GOOD_W'(ALT_GOOD);
  assign status.aisQuiet   = zerosNext <= ZER_W'(AIS_SET_MAX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      zeroRun  <= '0;
      window   <= '0;
      fill     <= '0;
      goodRun  <= '0;
      blkZeros <= '0;
    end else if (strobe.take) begin
      zeroRun  <= runNext;
      window   <= winNext;
      fill     <= fillNext;
      goodRun  <= goodRunNext;
      blkZeros <= strobe.blockEnd ? '0 : zerosNext;
    end
  end

  AST_ONE_RESTARTS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    strobe.take && rxBit && levelOk |=> zeroRun == '0);  // R5
  AST_LOW_LEVEL_IS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobe.take && !levelOk && (zeroRun < runLimit) |=> zeroRun != '0);  // R11
  AST_IDLE_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.take |=> $stable(zeroRun) && $stable(window) && $stable(blkZeros));  // R10

endmodule

// File: rtl/rx_alarm_control.sv
module rx_alarm_control
  import rx_alarm_pkg::*;
#(
  parameter int BLOCK = 512
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitEn,
  input  logic       modeAlt,
  input  dpStatus_t  status,
  output ctlStrobe_t strobe,
  output logic       rlos,
  output logic       ais
);

  localparam int BLK_W = $clog2(BLOCK);

  logic [BLK_W-1:0] blockCnt;
  logic             rlosQ, aisQ;
  logic             clearOk;

  assign strobe.take     = bitEn;
  assign strobe.blockEnd = bitEn && (blockCnt == BLK_W'(BLOCK - 1));

  assign clearOk = status.windowGood && (!modeAlt || status.altGoodMet);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      blockCnt <= '0;
      rlosQ    <= 1'b0;
      aisQ     <= 1'b0;
    end else if (strobe.take) begin
      blockCnt <= strobe.blockEnd ? '0 : blockCnt + 1'b1;
      if (status.runHit)       rlosQ <= 1'b1;
      else if (rlosQ && clearOk) rlosQ <= 1'b0;
      if (strobe.blockEnd)     aisQ <= status.aisQuiet;
    end
  end

  assign rlos = rlosQ;
  assign ais  = aisQ;

  AST_DECLARE_ON_RUN: assert property (@(posedge clk) disable iff (!rstN)
    strobe.take && status.runHit |=> rlosQ);  // R2
  AST_HOLD_WITHOUT_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    rlosQ && strobe.take && !status.windowGood |=> rlosQ);  // R6
  AST_ALT_WAITS: assert property (@(posedge clk) disable iff (!rstN)
    rlosQ && strobe.take && modeAlt && !status.altGoodMet |=> rlosQ);  // R7
  AST_AIS_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.blockEnd |=> $stable(aisQ));  // R8
  AST_IDLE_NO_ALARM_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    !bitEn |=> $stable(rlosQ) && $stable(aisQ));  // R10

endmodule

// File: rtl/rx_alarm_monitor.sv
module rx_alarm_monitor
  import rx_alarm_pkg::*;
#(
  parameter int WIN         = 32,
  parameter int MIN_ONES    = 4,
  parameter int MAX_ZRUN    = 15,
  parameter int SHORT_LIMIT = 32,
  parameter int LONG_LIMIT  = 2049,
  parameter int EXT_LIMIT   = 4096,
  parameter int ALT_GOOD    = 33,
  parameter int BLOCK       = 512,
  parameter int AIS_SET_MAX = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic bitEn,
  input  logic rxBit,
  input  logic levelOk,
  input  logic modeAlt,
  input  logic extLos,
  output logic rlos,
  output logic ais
);

  ctlStrobe_t strobe;
  dpStatus_t  status;

  rx_alarm_datapath #(
    .WIN(WIN), .MIN_ONES(MIN_ONES), .MAX_ZRUN(MAX_ZRUN),
    .SHORT_LIMIT(SHORT_LIMIT), .LONG_LIMIT(LONG_LIMIT), .EXT_LIMIT(EXT_LIMIT),
    .ALT_GOOD(ALT_GOOD), .AIS_SET_MAX(AIS_SET_MAX)
  ) uDatapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rxBit(rxBit),
    .levelOk(levelOk), .modeAlt(modeAlt), .extLos(extLos), .status(status)
  );

  rx_alarm_control #(
    .BLOCK(BLOCK)
  ) uControl (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .modeAlt(modeAlt),
    .status(status), .strobe(strobe), .rlos(rlos), .ais(ais)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> !rlos && !ais);  // R1

endmodule

// File: tb/rx_alarm_monitor_test.sv
`timescale 1ns/1ps
module rx_alarm_monitor_test;

  logic clk = 1'b0;
  logic rstN, bitEn, rxBit, levelOk, modeAlt, extLos;
  logic rlos, ais;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  rx_alarm_monitor uut (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .rxBit(rxBit), .levelOk(levelOk),
    .modeAlt(modeAlt), .extLos(extLos), .rlos(rlos), .ais(ais)
  );

  // reference model state
  int          mRun = 0, mFill = 0, mGood = 0, mBlk = 0, mZeros = 0;
  logic [31:0] mWin = '0;
  bit          mRlos = 0, mAis = 0;

  // scoreboard queues
  logic [1:0] expQ[$];
  string      tagQ[$];

  task automatic modelStep(input bit e);
    int limit, ones, cur, longest;
    bit good;
    limit = extLos ? 4096 : (modeAlt ? 2049 : 32);
    mRun  = e ? 0 : mRun + 1;
    mWin  = {mWin[30:0], e};
    if (mFill < 32) mFill++;
    ones = 0; cur = 0; longest = 0;
    for (int i = 0; i < 32; i++) begin
      if (mWin[i]) begin ones++; cur = 0; end
      else begin cur++; if (cur > longest) longest = cur; end
    end
    good  = (mFill >= 32) && (ones >= 4) && (longest <= 15);
    mGood = good ? mGood + 1 : 0;
    if (mRun >= limit) mRlos = 1;
    else if (mRlos && good && (!modeAlt || mGood >= 33)) mRlos = 0;
    if (!e) mZeros++;
    if (mBlk == 511) begin
      mAis = (mZeros <= 2);
      mZeros = 0;
      mBlk = 0;
    end else mBlk++;
  endtask

  task automatic sendBit(input bit b, input string tag);
    @(negedge clk);
    bitEn = 1'b1;
    rxBit = b;
    @(posedge clk);
    #1;
    bitEn = 1'b0;
    modelStep(b & levelOk);
    expQ.push_back({mRlos, mAis});
    tagQ.push_back(tag);
  endtask

  task automatic idleCycle(input string tag);
    @(negedge clk);
    bitEn = 1'b0;
    rxBit = ~rxBit;
    @(posedge clk);
    #1;
    expQ.push_back({mRlos, mAis});
    tagQ.push_back(tag);
  endtask

  task automatic sendRun(input bit b, input int n, input string tag);
    for (int i = 0; i < n; i++) sendBit(b, tag);
  endtask

  // one followed by seven zeros, repeated
  task automatic sendSparse(input int n, input string tag);
    for (int i = 0; i < n; i++) sendBit((i % 8) == 0, tag);
  endtask

  task automatic alignBlock(input string tag);
    while (mBlk != 0) sendBit(1'b1, tag);
  endtask

  // monitor: compare one queued result per falling edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      logic [1:0] exp;
      string tag;
      exp = expQ.pop_front();
      tag = tagQ.pop_front();
      checks++;
      if ({rlos, ais} !== exp) begin
        errors++;
        $display("FAIL %s: rlos/ais actual %b%b expected %b%b", tag, rlos, ais, exp[1], exp[0]);
      end
    end
  end

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; bitEn = 1'b0; rxBit = 1'b0;
    levelOk = 1'b1; modeAlt = 1'b0; extLos = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (rlos !== 1'b0 || ais !== 1'b0) begin
      errors++;
      $display("FAIL R1: rlos/ais actual %b%b expected 00", rlos, ais);
    end
    rstN = 1'b1;

    // R2 and R5: run restart by a one, then declare at 32 zeros
    sendRun(1'b1, 40, "R5");
    sendRun(1'b0, 31, "R2");
    sendBit(1'b1, "R5");
    sendRun(1'b0, 31, "R5");
    sendBit(1'b0, "R2");
    for (int i = 0; i < 5; i++) idleCycle("R10");
    sendSparse(40, "R6");

    // R8 and R9: all-ones hysteresis on block boundaries
    sendRun(1'b1, 100, "R8");
    alignBlock("R8");
    sendRun(1'b1, 1024, "R8");
    sendRun(1'b0, 2, "R8");
    sendRun(1'b1, 510, "R8");
    for (int i = 0; i < 5; i++) idleCycle("R10");
    sendRun(1'b0, 3, "R9");
    sendRun(1'b1, 509, "R9");

    // R11: low level turns ones into zeros
    levelOk = 1'b0;
    sendRun(1'b1, 32, "R11");
    levelOk = 1'b1;
    sendSparse(40, "R6");

    // R3 and R7: alternative mode
    modeAlt = 1'b1;
    sendRun(1'b1, 40, "R3");
    sendRun(1'b0, 2048, "R3");
    sendBit(1'b0, "R3");
    sendSparse(70, "R7");

    // R4: extended limit
    modeAlt = 1'b0;
    extLos = 1'b1;
    sendRun(1'b1, 40, "R4");
    sendRun(1'b0, 4095, "R4");
    sendBit(1'b0, "R4");
    sendSparse(40, "R6");
    extLos = 1'b0;

    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule